// File: doc/BRIEF.md
# Interrupt Response Bus Sequencer

This block runs the fixed series of bus operations that fills the time between a processor core accepting an interrupt and the first opcode fetch of the handler. A one-cycle accept pulse comes with a vector number and the current flags, code segment, instruction pointer and stack pointer. The block captures all of them in that cycle. The whole response always lasts exactly 42 clocks, whatever the vector number or data values.

Over those 42 clocks the block pushes three words through a push-request port: first the flags, then the code segment, then the instruction pointer. The stack pointer is lowered by two before each push. The block then reads the new instruction pointer and the new code segment from the vector table through a read-request port. Idle gaps of fixed length separate these operations. At the end the block pulses a fetch-start strobe, and at the same time it presents the new CS:IP pair.

Each phase length is a package constant. The accept-to-fetch distance is derived from those constants.

Top module: `irq_resp_seq`

## Requirements
- R1: After reset, busy, pushReq, readReq and fetchStart are all low, and newCs and newIp are zero.
- R2: An accept pulse sampled at a clock edge while busy is low starts a sequence. This edge is offset 0, and offset k means the cycle that follows the k-th edge after it. busy is high from offset 0 through offset 41 and is low at offset 42.
- R3: fetchStart is high for exactly one cycle, at offset 42. In that same cycle newIp and newCs hold the two words read from the vector table.
- R4: pushReq is high for one cycle each at offsets 5, 14 and 18 and is low at every other offset.
- R5: The three pushes carry, in order, the flags, the code segment and the instruction pointer captured at accept. Their pushAddr values are SP-2, SP-4 and SP-6, where SP is curSp at accept.
- R6: readReq is high for one cycle at offset 26 with readAddr = vector*4 (the IP word) and for one cycle at offset 33 with readAddr = vector*4+2 (the CS word). The IP word is sampled from readData at offset 29 and the CS word at offset 36, so readData must hold the word for readAddr from the request cycle up to that sampling cycle.
- R7: An accept pulse while busy is high has no effect: it changes neither the timing, nor the pushed values, nor the vector used. This includes a pulse at offset 41.
- R8: An accept pulse in the fetchStart cycle (offset 42) is taken, and it starts a new sequence whose fetchStart comes 42 clocks later.
- R9: In no cycle are more than one of pushReq, readReq and fetchStart high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| acceptValid | input | 1 | One-cycle pulse: interrupt accepted |
| vectorNum | input | 8 | Vector number, captured at accept |
| curFlags | input | 16 | Flags word to save |
| curCs | input | 16 | Code segment to save |
| curIp | input | 16 | Instruction pointer to save |
| curSp | input | 16 | Stack pointer before the pushes |
| busy | output | 1 | Sequence in progress |
| pushReq | output | 1 | One-cycle stack write request |
| pushAddr | output | 16 | Stack address of the push |
| pushData | output | 16 | Word to push |
| readReq | output | 1 | One-cycle vector table read request |
| readAddr | output | 10 | Byte address in the vector table |
| readData | input | 16 | Word returned for readAddr |
| fetchStart | output | 1 | One-cycle strobe: fetch the handler's first opcode |
| newCs | output | 16 | Handler code segment |
| newIp | output | 16 | Handler instruction pointer |

## Verification
The end of one response and the start of the next can fall in the same cycle: an accept pulse arrives exactly while fetchStart is high and busy has just dropped. The bench provokes this by issuing each new accept in the fetchStart cycle of the previous sequence. It then checks every output at every offset of the new sequence, so the new captures are judged against the values driven at that accept and not against stale ones. The same per-offset comparison covers accept pulses that arrive during a sequence, including one in the last busy cycle. These pulses come with junk data, so any leak into the pushed words, the read address or the timing shows up as a mismatch.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam int IDLE_A = 5;
  localparam int PUSH_F = 4;
  localparam int IDLE_B = 5;
  localparam int PUSH_C = 4;
  localparam int PUSH_I = 4;
  localparam int IDLE_C = 4;
  localparam int READ_I = 4;
  localparam int IDLE_D = 3;
  localparam int READ_C = 4;
  localparam int IDLE_E = 5;

  localparam int T_PF  = IDLE_A;
  localparam int T_PC  = T_PF + PUSH_F + IDLE_B;
  localparam int T_PI  = T_PC + PUSH_C;
  localparam int T_RI  = T_PI + PUSH_I + IDLE_C;
  localparam int T_RC  = T_RI + READ_I + IDLE_D;
  localparam int T_END = T_RC + READ_C + IDLE_E;
  localparam int CNT_W = $clog2(T_END + 1);

  typedef enum logic [1:0] {SEL_FLAGS = 2'd0, SEL_CS = 2'd1, SEL_IP = 2'd2} push_sel_e;

  typedef struct packed {
    logic      spDec;
    logic      pushStb;
    push_sel_e pushSel;
    logic      readStb;
    logic      readHi;
    logic      capIp;
    logic      capCs;
    logic      done;
  } strobe_t;
endpackage

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    acceptValid,
  output logic    busy,
  output logic    start,
  output strobe_t stb
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(T_END - 1);

  logic [CNT_W-1:0] cnt;

  assign start = acceptValid && !busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == LAST) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  function automatic logic at(input logic [CNT_W-1:0] c, input int t);
    return c == CNT_W'(t);
  endfunction

  always_comb begin
    stb.spDec   = busy && (at(cnt, T_PF - 1) || at(cnt, T_PC - 1) || at(cnt, T_PI - 1));
    stb.pushStb = busy && (at(cnt, T_PF) || at(cnt, T_PC) || at(cnt, T_PI));
    if (at(cnt, T_PF))      stb.pushSel = SEL_FLAGS;
    else if (at(cnt, T_PC)) stb.pushSel = SEL_CS;
    else                    stb.pushSel = SEL_IP;
    stb.readStb = busy && (at(cnt, T_RI) || at(cnt, T_RC));
    stb.readHi  = busy && (cnt >= CNT_W'(T_RI + READ_I));
    stb.capIp   = busy && at(cnt, T_RI + READ_I - 1);
    stb.capCs   = busy && at(cnt, T_RC + READ_C - 1);
    stb.done    = busy && (cnt == LAST);
  end

  a_r2_busy_hold: assert property (@(posedge clk) disable iff (!rstN)
    busy && !stb.done |=> busy);
  a_r3_done_ends: assert property (@(posedge clk) disable iff (!rstN)
    stb.done |=> !busy);
  a_r7_ignore_accept: assert property (@(posedge clk) disable iff (!rstN)
    busy && acceptValid && !stb.done |=> cnt == $past(cnt) + 1'b1);
  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.pushStb, stb.readStb, stb.done}));
endmodule

// File: rtl/irq_seq_dp.sv
module irq_seq_dp
  import irq_seq_pkg::*;
#(
  parameter int DW = 16,
  parameter int VW = 8,
  localparam int AW = VW + 2
)(
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  strobe_t       stb,
  input  logic [VW-1:0] vectorNum,
  input  logic [DW-1:0] curFlags,
  input  logic [DW-1:0] curCs,
  input  logic [DW-1:0] curIp,
  input  logic [DW-1:0] curSp,
  input  logic [DW-1:0] readData,
  output logic          pushReq,
  output logic [DW-1:0] pushAddr,
  output logic [DW-1:0] pushData,
  output logic          readReq,
  output logic [AW-1:0] readAddr,
  output logic          fetchStart,
  output logic [DW-1:0] newCs,
  output logic [DW-1:0] newIp
);
  logic [DW-1:0] flagsR, csR, ipR, spR;
  logic [VW-1:0] vecR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagsR <= '0;
      csR    <= '0;
      ipR    <= '0;
      spR    <= '0;
      vecR   <= '0;
    end else if (start) begin
      flagsR <= curFlags;
      csR    <= curCs;
      ipR    <= curIp;
      spR    <= curSp;
      vecR   <= vectorNum;
    end else if (stb.spDec) begin
      spR <= spR - DW'(2);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      newIp      <= '0;
      newCs      <= '0;
      fetchStart <= 1'b0;
    end else begin
      if (stb.capIp) newIp <= readData;
      if (stb.capCs) newCs <= readData;
      fetchStart <= stb.done;
    end
  end

  always_comb begin
    case (stb.pushSel)
      SEL_FLAGS: pushData = flagsR;
      SEL_CS:    pushData = csR;
      default:   pushData = ipR;
    endcase
  end

  assign pushReq  = stb.pushStb;
  assign pushAddr = spR;
  assign readReq  = stb.readStb;
  assign readAddr = {vecR, stb.readHi, 1'b0};

  a_r3_fetch_pulse: assert property (@(posedge clk) disable iff (!rstN)
    fetchStart |=> !fetchStart);
  a_r6_vector_held: assert property (@(posedge clk) disable iff (!rstN)
    stb.capIp |=> $stable(readAddr[AW-1:2]));
  a_r3_fetch_without_push: assert property (@(posedge clk) disable iff (!rstN)
    fetchStart |-> !pushReq && !readReq);
endmodule

// File: rtl/irq_resp_seq.sv
module irq_resp_seq
  import irq_seq_pkg::*;
#(
  parameter int DW = 16,
  parameter int VW = 8,
  localparam int AW = VW + 2
)(
  input  logic          clk,
  input  logic          rstN,
  input  logic          acceptValid,
  input  logic [VW-1:0] vectorNum,
  input  logic [DW-1:0] curFlags,
  input  logic [DW-1:0] curCs,
  input  logic [DW-1:0] curIp,
  input  logic [DW-1:0] curSp,
  output logic          busy,
  output logic          pushReq,
  output logic [DW-1:0] pushAddr,
  output logic [DW-1:0] pushData,
  output logic          readReq,
  output logic [AW-1:0] readAddr,
  input  logic [DW-1:0] readData,
  output logic          fetchStart,
  output logic [DW-1:0] newCs,
  output logic [DW-1:0] newIp
);
  logic    start;
  strobe_t stb;

  irq_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .acceptValid(acceptValid),
    .busy(busy), .start(start), .stb(stb)
  );

  irq_seq_dp #(.DW(DW), .VW(VW)) u_dp (
    .clk(clk), .rstN(rstN), .start(start), .stb(stb),
    .vectorNum(vectorNum), .curFlags(curFlags), .curCs(curCs),
    .curIp(curIp), .curSp(curSp), .readData(readData),
    .pushReq(pushReq), .pushAddr(pushAddr), .pushData(pushData),
    .readReq(readReq), .readAddr(readAddr), .fetchStart(fetchStart),
    .newCs(newCs), .newIp(newIp)
  );
endmodule

// File: tb/tb_irq_resp_seq.sv
module tb_irq_resp_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        acceptValid = 1'b0;
  logic [7:0]  vectorNum = '0;
  logic [15:0] curFlags = '0, curCs = '0, curIp = '0, curSp = '0;
  logic        busy, pushReq, readReq, fetchStart;
  logic [15:0] pushAddr, pushData, readData, newCs, newIp;
  logic [9:0]  readAddr;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [15:0] memWord(input logic [9:0] a);
    return (16'(a) * 16'h9e37) ^ 16'h5a5a;
  endfunction

  assign readData = memWord(readAddr);

  irq_resp_seq dut (
    .clk(clk), .rstN(rstN), .acceptValid(acceptValid), .vectorNum(vectorNum),
    .curFlags(curFlags), .curCs(curCs), .curIp(curIp), .curSp(curSp),
    .busy(busy), .pushReq(pushReq), .pushAddr(pushAddr), .pushData(pushData),
    .readReq(readReq), .readAddr(readAddr), .readData(readData),
    .fetchStart(fetchStart), .newCs(newCs), .newIp(newIp)
  );

  task automatic chk(input string tag, input logic ok, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic junkInputs(input logic acc);
    acceptValid = acc;
    vectorNum   = 8'($urandom);
    curFlags    = 16'($urandom);
    curCs       = 16'($urandom);
    curIp       = 16'($urandom);
    curSp       = 16'($urandom);
  endtask

  // Called just after a negedge; the accept is sampled at the next posedge.
  task automatic runSeq(input logic [7:0] vec, input logic [15:0] fl,
                        input logic [15:0] cs, input logic [15:0] ip,
                        input logic [15:0] sp, input int noiseK);
    logic [9:0] base;
    base = {vec, 2'b00};
    acceptValid = 1'b1; vectorNum = vec;
    curFlags = fl; curCs = cs; curIp = ip; curSp = sp;
    @(posedge clk);
    @(negedge clk);
    for (int k = 0; k <= 42; k++) begin
      junkInputs(k == noiseK);
      chk("R2 busy", busy == (k < 42), 32'(busy), 32'(k < 42));
      chk("R9 exclusive", $countones({pushReq, readReq, fetchStart}) <= 1,
          32'({pushReq, readReq, fetchStart}), 32'd0);
      chk("R3 fetchStart", fetchStart == (k == 42), 32'(fetchStart), 32'(k == 42));
      chk("R4 pushReq", pushReq == (k == 5 || k == 14 || k == 18),
          32'(pushReq), 32'(k == 5 || k == 14 || k == 18));
      chk("R6 readReq", readReq == (k == 26 || k == 33),
          32'(readReq), 32'(k == 26 || k == 33));
      if (k == 5) begin
        chk("R5 flags data", pushData == fl, 32'(pushData), 32'(fl));
        chk("R5 flags addr", pushAddr == sp - 16'd2, 32'(pushAddr), 32'(sp - 16'd2));
      end
      if (k == 14) begin
        chk("R5 cs data", pushData == cs, 32'(pushData), 32'(cs));
        chk("R5 cs addr", pushAddr == sp - 16'd4, 32'(pushAddr), 32'(sp - 16'd4));
      end
      if (k == 18) begin
        chk("R5 ip data", pushData == ip, 32'(pushData), 32'(ip));
        chk("R5 ip addr", pushAddr == sp - 16'd6, 32'(pushAddr), 32'(sp - 16'd6));
      end
      if (k == 26) chk("R6 ip addr", readAddr == base, 32'(readAddr), 32'(base));
      if (k == 33) chk("R6 cs addr", readAddr == base + 10'd2, 32'(readAddr), 32'(base + 10'd2));
      if (k == 42) begin
        chk("R3 newIp", newIp == memWord(base), 32'(newIp), 32'(memWord(base)));
        chk("R3 newCs", newCs == memWord(base + 10'd2), 32'(newCs), 32'(memWord(base + 10'd2)));
      end
      if (k < 42) @(negedge clk);
    end
  endtask

  task automatic idleCycles(input int n);
    for (int i = 0; i < n; i++) begin
      acceptValid = 1'b0;
      @(negedge clk);
      chk("R2 idle busy", busy == 1'b0, 32'(busy), 32'd0);
      chk("R3 idle fetch", fetchStart == 1'b0, 32'(fetchStart), 32'd0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    chk("R1 busy", busy == 1'b0, 32'(busy), 32'd0);
    chk("R1 pushReq", pushReq == 1'b0, 32'(pushReq), 32'd0);
    chk("R1 readReq", readReq == 1'b0, 32'(readReq), 32'd0);
    chk("R1 fetchStart", fetchStart == 1'b0, 32'(fetchStart), 32'd0);
    chk("R1 newCs newIp", newCs == 16'd0 && newIp == 16'd0,
        32'({newCs, newIp}), 32'd0);
    rstN = 1'b1;
    idleCycles(2);

    // Directed: lowest and highest vector, SP near wrap.
    runSeq(8'd0, 16'h0202, 16'h1234, 16'h5678, 16'h0004, -1);
    idleCycles(3);
    runSeq(8'd255, 16'hffff, 16'hf000, 16'hfff0, 16'hfffe, -1);
    idleCycles(1);
    // R7: accept pulses during busy, including the last busy cycle.
    runSeq(8'd17, 16'h0046, 16'h0100, 16'h0200, 16'h8000, 3);
    idleCycles(1);
    runSeq(8'd18, 16'h0046, 16'h0300, 16'h0400, 16'h7000, 41);
    // R8: back-to-back, the accept lands in the fetchStart cycle.
    runSeq(8'd99, 16'h1111, 16'h2222, 16'h3333, 16'h4444, 20);
    runSeq(8'd100, 16'haaaa, 16'hbbbb, 16'hcccc, 16'hdddd, -1);
    idleCycles(2);

    // Constrained random sequences, some chained.
    for (int n = 0; n < 12; n++) begin
      runSeq(8'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
             16'($urandom), int'($urandom_range(0, 45)));
      if ($urandom_range(0, 1) == 1) idleCycles(int'($urandom_range(1, 4)));
    end
    idleCycles(2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule